// File: doc/BRIEF.md
# PHY PLL Power Sequencer

This block is a register-bus master that brings a serial PHY's PLL and its PHY power control up or down on request. A power-on request first reads the PLL status. If the PLL is not yet locked, the block picks divider settings from a four-entry table keyed on the system clock rate. It writes them into the PLL configuration registers, one field at a time, with read-modify-write accesses. It then starts the PLL and waits for lock. If the PLL is already locked, the block skips programming and only takes the PLL out of idle when needed. When the PLL is ready, the block turns on the PHY clock command and records the clock rate in MHz.

A power-off request clears the PHY clock command, puts the PLL into idle, and waits until the oscillator and the regulator report power-down. Every wait is a bounded poll that samples the status register once per millisecond tick. Completion is reported with a one-cycle `done` pulse. Failure is reported with a one-cycle `err` pulse and a code naming the phase that failed.

Top module: `phy_pll_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err`, `err_code` and `bus_valid` are all 0. A reset during a sequence abandons it, and no further bus access follows.
- R2: A power-on request is served only when `sys_rate_hz` equals one of the table rates exactly (defaults 12 000 000, 19 200 000, 20 000 000 and 26 000 000 Hz). With no match, `err` pulses with code 1 and no bus access of any kind is made.
- R3: On power-on with status bit 1 clear, five read-modify-write steps run in this order:
  - N into 0x0C bits [8:1]
  - DCO select into 0x10 bits [3:1]
  - M into 0x0C bits [20:9]
  - fractional M into 0x20 bits [17:0]
  - sigma-delta divider into 0x14 bits [17:10]

  Each step leaves all other bits unchanged. The value 1 is then written to 0x08.
- R4: Lock is status (0x04) bit 1. After the start write, status is read once per tick, for at most 100 reads. If lock is never seen, `err` pulses with code 2 and the PHY register is not written.
- R5: On power-on with status bit 1 already set, no divider field is written. If 0x10 bit 0 is set, it is cleared and the lock wait of R4 follows. If it is clear, the block moves straight to the PHY step.
- R6: The PHY step is a read-modify-write of the PHY power register (default 0x40). It sets bits [21:14] to 3 and bits [31:22] to the rate in whole MHz, and keeps bits [13:0].
- R7: Power-off first writes 0 into PHY register bits [21:14] and keeps all other bits. It then sets 0x10 bit 0. Next it reads status once per tick, for at most 100 reads, until bits 16 and 15 are both 1. If they never are, `err` pulses with code 3.
- R8: Only one bus access is outstanding at a time. `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold steady until the cycle in which `bus_ready` is sampled high.
- R9: Requests that arrive while `busy` is high are ignored. When both requests arrive together in idle, the power-on request is taken.
- R10: `done` and `err` are one-cycle pulses and never high together. `err_code` is nonzero while `err` is high. `busy` is high while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_rate_hz | input | 32 | System clock rate in Hz, used to select the divider table entry |
| tick_ms | input | 1 | One-cycle pulse per millisecond; paces the status polls |
| pwr_on_req | input | 1 | Start a power-on sequence |
| pwr_off_req | input | 1 | Start a power-off sequence |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on failure |
| err_code | output | 2 | Failure reason: 1 no rate match, 2 lock timeout, 3 power-down timeout |
| bus_valid | output | 1 | A register access is requested |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access acknowledge; read data is valid in this cycle |
| bus_rdata | input | 32 | Read data |

## Verification
The bench presets the configuration registers with patterns whose bits are all ones or checkerboards. A read-modify-write that clobbered neighbouring bits would therefore change the values read back, and a field placed at the wrong bit position would show up the same way.

It runs both skip paths: locked with idle set, and locked with idle clear. A design that reprogrammed a locked PLL, or wrote configuration2 needlessly, would show extra writes.

It counts the exact number of status reads in both timeout cases. A poll that ran too long, ended too early, or read without waiting for a tick would give a count other than 100.

Further tests cover an unmatched rate, which must produce no bus traffic, and requests issued mid-sequence, which must be dropped. They also cover simultaneous requests and a reset in the middle of a sequence.

// File: rtl/phy_pll_seq_pkg.sv
`timescale 1ns/1ps
package phy_pll_seq_pkg;

    localparam int DW = 32;
    localparam int AW = 8;
    localparam int MHZ_W = 10;

    localparam logic [AW-1:0] A_STAT = 8'h04;
    localparam logic [AW-1:0] A_GO   = 8'h08;
    localparam logic [AW-1:0] A_CFG1 = 8'h0C;
    localparam logic [AW-1:0] A_CFG2 = 8'h10;
    localparam logic [AW-1:0] A_CFG3 = 8'h14;
    localparam logic [AW-1:0] A_CFG4 = 8'h20;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NO_RATE = 2'd1,
        ERR_LOCK_TO = 2'd2,
        ERR_PDN_TO  = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        OP_N, OP_DCO, OP_M, OP_MF, OP_SD,
        OP_IDLE_CLR, OP_IDLE_SET, OP_PHY_ON, OP_PHY_OFF
    } op_e;

    typedef struct packed {
        logic [11:0] m;
        logic [7:0]  n;
        logic [17:0] mf;
        logic [7:0]  sd;
        logic [2:0]  dco;
    } pll_cfg_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] mask;
        logic [DW-1:0] val;
    } rmw_t;

    // Target register, field mask and field value of each read-modify-write step
    function automatic rmw_t op_rmw(op_e op, pll_cfg_t c, logic [MHZ_W-1:0] mhz,
                                    logic [AW-1:0] phy_addr);
        rmw_t r;
        r = '0;
        case (op)
            OP_N:        begin r.addr = A_CFG1; r.mask = 32'h0000_01FE; r.val = DW'(c.n) << 1;   end
            OP_DCO:      begin r.addr = A_CFG2; r.mask = 32'h0000_000E; r.val = DW'(c.dco) << 1; end
            OP_M:        begin r.addr = A_CFG1; r.mask = 32'h001F_FE00; r.val = DW'(c.m) << 9;   end
            OP_MF:       begin r.addr = A_CFG4; r.mask = 32'h0003_FFFF; r.val = DW'(c.mf);       end
            OP_SD:       begin r.addr = A_CFG3; r.mask = 32'h0003_FC00; r.val = DW'(c.sd) << 10; end
            OP_IDLE_CLR: begin r.addr = A_CFG2; r.mask = 32'h0000_0001; r.val = 32'h0;           end
            OP_IDLE_SET: begin r.addr = A_CFG2; r.mask = 32'h0000_0001; r.val = 32'h1;           end
            OP_PHY_ON:   begin r.addr = phy_addr; r.mask = 32'hFFFF_C000; r.val = {mhz, 8'd3, 14'd0}; end
            OP_PHY_OFF:  begin r.addr = phy_addr; r.mask = 32'h003F_C000; r.val = 32'h0;         end
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_rate_lookup.sv
`timescale 1ns/1ps
module pll_rate_lookup
    import phy_pll_seq_pkg::*;
#(
    parameter int NUM_RATES = 4,
    parameter logic [NUM_RATES-1:0][DW-1:0] RATE_HZ = '0,
    parameter pll_cfg_t [NUM_RATES-1:0] RATE_CFG = '0
)(
    input  logic [DW-1:0]    rate,
    output logic             hit,
    output pll_cfg_t         cfg,
    output logic [MHZ_W-1:0] mhz
);
    logic [NUM_RATES-1:0]             match;
    logic [NUM_RATES-1:0][MHZ_W-1:0] mhz_tbl;

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_ent
        localparam logic [MHZ_W-1:0] ENT_MHZ = MHZ_W'(RATE_HZ[i] / 1000000);
        assign match[i]   = (rate == RATE_HZ[i]);
        assign mhz_tbl[i] = ENT_MHZ;
    end

    // Lowest index wins if the table holds a rate twice
    always_comb begin
        hit = 1'b0;
        cfg = '0;
        mhz = '0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                cfg = RATE_CFG[i];
                mhz = mhz_tbl[i];
            end
        end
    end
endmodule

// File: rtl/pll_poll_timer.sv
`timescale 1ns/1ps
module pll_poll_timer #(
    parameter int LIMIT = 100
)(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sample,
    output logic exhausted
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (sample && !exhausted)
            cnt <= cnt + 1'b1;
    end

    assign exhausted = (cnt == CW'(LIMIT));

    // R4, R7: the number of status samples never exceeds the bound
    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));
endmodule

// File: rtl/phy_pll_seq.sv
`timescale 1ns/1ps
module phy_pll_seq
    import phy_pll_seq_pkg::*;
#(
    parameter int NUM_RATES = 4,
    parameter int TIMEOUT_TICKS = 100,
    parameter logic [AW-1:0] PHY_PWR_ADDR = 8'h40,
    parameter logic [NUM_RATES-1:0][DW-1:0] RATE_HZ =
        {32'd26000000, 32'd20000000, 32'd19200000, 32'd12000000},
    parameter pll_cfg_t [NUM_RATES-1:0] RATE_CFG = {
        {12'd1250, 8'd12, 18'd0,     8'd26, 3'd4},
        {12'd1000, 8'd7,  18'd0,     8'd14, 3'd2},
        {12'd1172, 8'd8,  18'd65536, 8'd17, 3'd4},
        {12'd1250, 8'd5,  18'd0,     8'd20, 3'd4}}
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sys_rate_hz,
    input  logic          tick_ms,
    input  logic          pwr_on_req,
    input  logic          pwr_off_req,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_code,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_STAT_RD, S_RMW_RD, S_RMW_WR, S_GO, S_WAIT, S_POLL
    } state_e;

    state_e           state;
    op_e              op_q;
    pll_cfg_t         cfg_q;
    logic [MHZ_W-1:0] mhz_q;
    logic [DW-1:0]    rd_val;
    logic             wait_pdn;
    logic             done_q, err_q;
    err_e             code_q;

    logic             hit;
    pll_cfg_t         lk_cfg;
    logic [MHZ_W-1:0] lk_mhz;
    logic             exhausted;
    logic             poll_met;
    rmw_t             rmw;

    pll_rate_lookup #(
        .NUM_RATES(NUM_RATES), .RATE_HZ(RATE_HZ), .RATE_CFG(RATE_CFG)
    ) u_lookup (
        .rate(sys_rate_hz), .hit(hit), .cfg(lk_cfg), .mhz(lk_mhz)
    );

    pll_poll_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst(rst),
        .clr(state == S_IDLE),
        .sample(state == S_WAIT && tick_ms),
        .exhausted(exhausted)
    );

    assign rmw      = op_rmw(op_q, cfg_q, mhz_q, PHY_PWR_ADDR);
    assign poll_met = wait_pdn ? (bus_rdata[16] && bus_rdata[15]) : bus_rdata[1];

    always_comb begin
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = A_STAT;
        bus_wdata = '0;
        case (state)
            S_STAT_RD, S_POLL: ;
            S_RMW_RD: bus_addr = rmw.addr;
            S_RMW_WR: begin
                bus_write = 1'b1;
                bus_addr  = rmw.addr;
                bus_wdata = (rd_val & ~rmw.mask) | (rmw.val & rmw.mask);
            end
            S_GO: begin
                bus_write = 1'b1;
                bus_addr  = A_GO;
                bus_wdata = 32'h1;
            end
            default: bus_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_N;
            cfg_q    <= '0;
            mhz_q    <= '0;
            rd_val   <= '0;
            wait_pdn <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            code_q   <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (pwr_on_req) begin
                        if (hit) begin
                            cfg_q <= lk_cfg;
                            mhz_q <= lk_mhz;
                            state <= S_STAT_RD;
                        end else begin
                            err_q  <= 1'b1;
                            code_q <= ERR_NO_RATE;
                        end
                    end else if (pwr_off_req) begin
                        op_q  <= OP_PHY_OFF;
                        state <= S_RMW_RD;
                    end
                end
                S_STAT_RD: if (bus_ready) begin
                    op_q  <= bus_rdata[1] ? OP_IDLE_CLR : OP_N;
                    state <= S_RMW_RD;
                end
                S_RMW_RD: if (bus_ready) begin
                    rd_val <= bus_rdata;
                    if (op_q == OP_IDLE_CLR && !bus_rdata[0])
                        op_q <= OP_PHY_ON;
                    else
                        state <= S_RMW_WR;
                end
                S_RMW_WR: if (bus_ready) begin
                    state <= S_RMW_RD;
                    case (op_q)
                        OP_N:        op_q <= OP_DCO;
                        OP_DCO:      op_q <= OP_M;
                        OP_M:        op_q <= OP_MF;
                        OP_MF:       op_q <= OP_SD;
                        OP_SD:       state <= S_GO;
                        OP_PHY_OFF:  op_q <= OP_IDLE_SET;
                        OP_IDLE_CLR: begin state <= S_WAIT; wait_pdn <= 1'b0; end
                        OP_IDLE_SET: begin state <= S_WAIT; wait_pdn <= 1'b1; end
                        default: begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end
                    endcase
                end
                S_GO: if (bus_ready) begin
                    state    <= S_WAIT;
                    wait_pdn <= 1'b0;
                end
                S_WAIT: if (tick_ms) state <= S_POLL;
                S_POLL: if (bus_ready) begin
                    if (poll_met) begin
                        if (wait_pdn) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            op_q  <= OP_PHY_ON;
                            state <= S_RMW_RD;
                        end
                    end else if (exhausted) begin
                        state  <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= wait_pdn ? ERR_PDN_TO : ERR_LOCK_TO;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = err_q ? code_q : ERR_NONE;

    // R8: an unacknowledged request holds its content
    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                      && $stable(bus_write) && $stable(bus_wdata)));
    // R1: no bus traffic outside a sequence
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_valid);
    // R2: unmatched rate fails at once without traffic
    assert_no_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && pwr_on_req && !hit) |=> (err && err_code == ERR_NO_RATE && !bus_valid));
    // R10: pulse shape and code
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    assert_err_code_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_code != 2'd0));
    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
endmodule

// File: tb/phy_pll_seq_tb.sv
`timescale 1ns/1ps
module phy_pll_seq_tb;

    typedef struct packed {
        logic        off;
        logic [31:0] rate;
        logic        pre_lock;
        logic        pre_idle;
        logic        lock_ok;
        logic        pdn_ok;
        logic [1:0]  code;
        logic [7:0]  nwr;
        logic [7:0]  nrd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd12000000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd7, 8'd2},
        '{1'b0, 32'd19200000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd7, 8'd2},
        '{1'b0, 32'd26000000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd7, 8'd2},
        '{1'b0, 32'd13000000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd0, 8'd0},
        '{1'b0, 32'd20000000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'd2, 8'd2},
        '{1'b0, 32'd20000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'd1, 8'd1},
        '{1'b0, 32'd12000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'd6, 8'd101},
        '{1'b1, 32'd19200000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 8'd2, 8'd1},
        '{1'b1, 32'd19200000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 8'd2, 8'd100}
    };
    localparam int ACK_DLY = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sys_rate_hz = 32'd12000000;
    logic        tick_ms = 1'b0;
    logic        pwr_on_req = 1'b0;
    logic        pwr_off_req = 1'b0;
    logic        busy, done, err;
    logic [1:0]  err_code;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = 32'h0;

    int checks = 0;
    int fails = 0;

    logic [31:0] mem [64];
    logic [7:0]  wlog [16];
    int nwr, nrd, hold_viol, wcnt, tcnt;
    logic lock_ok, pdn_ok;
    logic hold_prev;
    logic [7:0]  p_addr;
    logic [31:0] p_wdata;
    logic        p_write;

    phy_pll_seq u_dut (
        .clk(clk), .rst(rst), .sys_rate_hz(sys_rate_hz), .tick_ms(tick_ms),
        .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    // Tick source: one pulse every 10 cycles
    always @(negedge clk) begin
        tcnt = (tcnt >= 9) ? 0 : tcnt + 1;
        tick_ms = (tcnt == 9);
    end

    // Register model with delayed acknowledge and handshake monitor
    always @(negedge clk) begin
        if (rst) begin
            bus_ready = 1'b0;
            wcnt = 0;
            hold_prev = 1'b0;
        end else begin
            if (hold_prev && (!bus_valid || bus_addr != p_addr ||
                              bus_write != p_write || bus_wdata != p_wdata))
                hold_viol++;
            if (bus_ready) begin
                bus_ready = 1'b0;
            end else if (bus_valid) begin
                if (wcnt == ACK_DLY) begin
                    wcnt = 0;
                    bus_ready = 1'b1;
                    if (bus_write) begin
                        mem[bus_addr[7:2]] = bus_wdata;
                        if (nwr < 16) wlog[nwr] = bus_addr;
                        nwr++;
                        if (bus_addr == 8'h08 && lock_ok) mem[1][1] = 1'b1;
                        if (bus_addr == 8'h10) begin
                            if (!bus_wdata[0] && lock_ok) mem[1][1] = 1'b1;
                            if (bus_wdata[0]) begin
                                mem[1][1] = 1'b0;
                                if (pdn_ok) mem[1][16:15] = 2'b11;
                            end
                        end
                    end else begin
                        bus_rdata = mem[bus_addr[7:2]];
                        if (bus_addr == 8'h04) nrd++;
                    end
                end else begin
                    wcnt++;
                end
            end
            hold_prev = bus_valid && !bus_ready;
            p_addr = bus_addr;
            p_write = bus_write;
            p_wdata = bus_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic table_of(input logic [31:0] rate, output logic [11:0] m,
                            output logic [7:0] n, output logic [17:0] mf,
                            output logic [7:0] sd, output logic [2:0] dco,
                            output logic [9:0] mhz);
        case (rate)
            32'd12000000: begin m = 1250; n = 5;  mf = 0;     sd = 20; dco = 4; mhz = 12; end
            32'd19200000: begin m = 1172; n = 8;  mf = 65536; sd = 17; dco = 4; mhz = 19; end
            32'd20000000: begin m = 1000; n = 7;  mf = 0;     sd = 14; dco = 2; mhz = 20; end
            default:      begin m = 1250; n = 12; mf = 0;     sd = 26; dco = 4; mhz = 26; end
        endcase
    endtask

    task automatic preset(input logic plock, input logic pidle, input logic [31:0] phy,
                          input logic lok, input logic pok);
        for (int k = 0; k < 64; k++) mem[k] = 32'h0;
        mem[1]  = plock ? 32'h2 : 32'h0;
        mem[3]  = 32'hA5A5_A5A5;
        mem[4]  = 32'h5A5A_5A5A | {31'h0, pidle};
        mem[5]  = 32'hFFFF_FFFF;
        mem[8]  = 32'hFFFF_FFFF;
        mem[16] = phy;
        lock_ok = lok;
        pdn_ok  = pok;
        nwr = 0;
        nrd = 0;
        for (int k = 0; k < 16; k++) wlog[k] = 8'h0;
    endtask

    // Pulse the requests for one cycle, then wait for the end pulse
    task automatic run(input logic on, input logic off, output logic [1:0] code,
                       output logic ended, output logic saw_busy);
        pwr_on_req  = on;
        pwr_off_req = off;
        @(negedge clk);
        pwr_on_req  = 1'b0;
        pwr_off_req = 1'b0;
        ended = 1'b0;
        saw_busy = 1'b0;
        code = 2'd0;
        for (int c = 0; c < 5000 && !ended; c++) begin
            if (busy) saw_busy = 1'b1;
            if (done || err) begin
                ended = 1'b1;
                code = err ? err_code : 2'd0;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        chk(!done && !err, "R10", "end pulse lasts one cycle", {30'h0, done, err}, 32'h0);
    endtask

    initial begin
        logic [1:0] code;
        logic ended, saw_busy;
        logic [11:0] m; logic [7:0] n; logic [17:0] mf; logic [7:0] sd;
        logic [2:0] dco; logic [9:0] mhz;
        logic [31:0] pre_phy, exp_phy, exp_c2;
        int nw_snap;

        tcnt = 0;
        nwr = 0; nrd = 0; hold_viol = 0; wcnt = 0;
        preset(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk({busy, done, err, err_code, bus_valid} == 6'b0, "R1", "state during reset",
            {26'h0, busy, done, err, err_code, bus_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_valid, "R1", "idle after reset", {30'h0, busy, bus_valid}, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            pre_phy = VECS[i].off ? {10'd19, 8'd3, 14'h1234} : 32'h0000_1234;
            preset(VECS[i].pre_lock, VECS[i].pre_idle, pre_phy, VECS[i].lock_ok, VECS[i].pdn_ok);
            sys_rate_hz = VECS[i].rate;
            table_of(VECS[i].rate, m, n, mf, sd, dco, mhz);
            run(!VECS[i].off, VECS[i].off, code, ended, saw_busy);
            chk(ended, "R10", $sformatf("vec %0d completes", i), {31'h0, ended}, 32'h1);
            chk(code == VECS[i].code, "R2 R4 R7", $sformatf("vec %0d error code", i),
                {30'h0, code}, {30'h0, VECS[i].code});
            chk(nwr == VECS[i].nwr, "R3 R5 R7", $sformatf("vec %0d write count", i),
                nwr, {24'h0, VECS[i].nwr});
            chk(nrd == VECS[i].nrd, "R4 R7", $sformatf("vec %0d status reads", i),
                nrd, {24'h0, VECS[i].nrd});
            if (VECS[i].code != 2'd1)
                chk(saw_busy, "R10", $sformatf("vec %0d busy seen", i), {31'h0, saw_busy}, 32'h1);
            if (!VECS[i].off && !VECS[i].pre_lock && VECS[i].code != 2'd1) begin
                chk(mem[3] == ((32'hA5A5_A5A5 & ~32'h001F_FFFE) | (32'(m) << 9) | (32'(n) << 1)),
                    "R3", $sformatf("vec %0d N and M fields", i), mem[3],
                    (32'hA5A5_A5A5 & ~32'h001F_FFFE) | (32'(m) << 9) | (32'(n) << 1));
                chk(mem[4] == ((32'h5A5A_5A5A & ~32'hE) | (32'(dco) << 1)), "R3",
                    $sformatf("vec %0d DCO field", i), mem[4],
                    (32'h5A5A_5A5A & ~32'hE) | (32'(dco) << 1));
                chk(mem[5] == ((32'hFFFF_FFFF & ~32'h0003_FC00) | (32'(sd) << 10)), "R3",
                    $sformatf("vec %0d SD field", i), mem[5],
                    (32'hFFFF_FFFF & ~32'h0003_FC00) | (32'(sd) << 10));
                chk(mem[8] == (32'hFFFC_0000 | 32'(mf)), "R3",
                    $sformatf("vec %0d fractional M", i), mem[8], 32'hFFFC_0000 | 32'(mf));
                chk(mem[2] == 32'h1, "R3", $sformatf("vec %0d start write", i), mem[2], 32'h1);
            end
            if (VECS[i].pre_lock && !VECS[i].off)
                chk(mem[3] == 32'hA5A5_A5A5, "R5", $sformatf("vec %0d dividers untouched", i),
                    mem[3], 32'hA5A5_A5A5);
            if (VECS[i].off)
                exp_phy = pre_phy & ~32'h003F_C000;
            else if (VECS[i].code == 2'd0)
                exp_phy = (pre_phy & 32'h3FFF) | (32'd3 << 14) | (32'(mhz) << 22);
            else
                exp_phy = pre_phy;
            chk(mem[16] == exp_phy, "R6 R7 R4", $sformatf("vec %0d PHY power register", i),
                mem[16], exp_phy);
            exp_c2 = mem[4];
            if (VECS[i].off)
                chk(exp_c2[0] == 1'b1, "R7", $sformatf("vec %0d idle bit set", i),
                    {31'h0, exp_c2[0]}, 32'h1);
            else if (VECS[i].pre_lock)
                chk(exp_c2 == 32'h5A5A_5A5A, "R5", $sformatf("vec %0d idle cleared", i),
                    exp_c2, 32'h5A5A_5A5A);
        end

        // R3: write order for a full programming run
        preset(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
        sys_rate_hz = 32'd19200000;
        run(1'b1, 1'b0, code, ended, saw_busy);
        chk({wlog[0], wlog[1], wlog[2], wlog[3]} == {8'h0C, 8'h10, 8'h0C, 8'h20}, "R3",
            "write order first four", {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'h0C100C20);
        chk({wlog[4], wlog[5], wlog[6]} == {8'h14, 8'h08, 8'h40}, "R3 R6",
            "write order last three", {8'h0, wlog[4], wlog[5], wlog[6]}, 32'h00140840);

        // R9: power-off during a power-on sequence is dropped
        preset(1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
        sys_rate_hz = 32'd12000000;
        pwr_on_req = 1'b1;
        @(negedge clk);
        pwr_on_req = 1'b0;
        repeat (5) @(negedge clk);
        pwr_off_req = 1'b1;
        @(negedge clk);
        pwr_off_req = 1'b0;
        for (int c = 0; c < 3000 && !(done || err); c++) @(negedge clk);
        chk(done, "R9", "on sequence finishes despite off request", {31'h0, done}, 32'h1);
        repeat (40) @(negedge clk);
        chk(nwr == 7 && mem[16][21:14] == 8'd3, "R9", "off request ignored while busy",
            {nwr[15:0], 8'h0, mem[16][21:14]}, {16'd7, 8'h0, 8'd3});

        // R9: simultaneous requests take the power-on path
        preset(1'b1, 1'b0, 32'h0, 1'b1, 1'b1);
        sys_rate_hz = 32'd20000000;
        run(1'b1, 1'b1, code, ended, saw_busy);
        chk(mem[16] == ((32'd3 << 14) | (32'd20 << 22)), "R9", "both requests: on wins",
            mem[16], (32'd3 << 14) | (32'd20 << 22));

        // R1: reset in mid sequence abandons it
        preset(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
        sys_rate_hz = 32'd12000000;
        pwr_on_req = 1'b1;
        @(negedge clk);
        pwr_on_req = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_valid, "R1", "idle after mid-sequence reset",
            {30'h0, busy, bus_valid}, 32'h0);
        nw_snap = nwr;
        repeat (60) @(negedge clk);
        chk(nwr == nw_snap && !bus_valid, "R1", "no traffic after reset", nwr, nw_snap);

        chk(hold_viol == 0, "R8", "request held until acknowledge", hold_viol, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule